// File: doc/BRIEF.md
# Three-Lane In-Order Issue Unit

This block sits between the decode buffer and three execution lanes of an in-order core. Each cycle it looks at up to three decoded instructions, oldest first. It decides how many of them leave decode and steers each issuing instruction to a lane that can execute its class. The lanes are not equal. Lane X runs branches and ALU work. Lanes Y and Z run loads, stores and ALU work.

A per-register countdown scoreboard records when each in-flight result becomes available for bypassing. Any instruction whose operands are not yet available stays in decode. A hazard inside the group does the same. Once one instruction stops, every younger instruction in the group stops with it. The issue count returns to the decode buffer, which drops that many entries from its head.

A branch is predicted not taken and is resolved one cycle after it issues, in the first execute stage of lane X. A taken resolution raises a redirect pulse and suppresses issue in that cycle, so nothing younger than the branch leaves decode.

Top module: `issue_unit`

## Requirements
- R1: Slots are taken oldest first (slot 0 oldest). The issue count is the length of the leading run of issuable slots, from 0 to 3. Exactly that many lanes show valid, with lane bit 0 = X, bit 1 = Y and bit 2 = Z.
- R2: Class codes are ALU=0, load=1, store=2, branch=3, and slot k's code sits in bits [2k+1:2k]. Lane X never receives a load or a store, and lanes Y and Z never receive a branch.
- R3: A branch takes X. A load or store takes Y if it is free, otherwise Z. An ALU operation takes X, then Y, then Z, but it skips X when a younger valid slot in the same group holds a branch.
- R4: An instruction that finds no free capable lane does not issue, and neither does any younger slot in the group.
- R5: A reader of a load destination cannot issue in the cycle right after the load issues. It can issue one cycle later. A reader of an ALU result can issue in the very next cycle. A stalled slot also holds back every younger slot.
- R6: A slot that reads, or also writes, the destination of an older writing slot in the same group does not issue in that cycle.
- R7: An ALU write to a register that still has a load pending stalls until the load's countdown has expired.
- R8: Register 0 never creates a dependency, either as a source or as a destination.
- R9: A branch closes its group: no slot younger than an issuing branch issues in the same cycle.
- R10: The taken input is honoured only in the cycle after a branch issued to X. In that cycle the redirect output is high and the issue count is 0. Otherwise the taken input is ignored.
- R11: Stores and branches write no register, so their destination field never delays a later reader.
- R12: After reset no lane is valid, the redirect output is low, and no register is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_valid_i | input | 3 | Occupied decode slots, contiguous from slot 0 |
| slot_cls_i | input | 6 | Class code per slot, 2 bits each |
| slot_dst_i | input | 3×REG_W | Destination register per slot |
| slot_src1_i | input | 3×REG_W | First source register per slot |
| slot_src2_i | input | 3×REG_W | Second source register per slot |
| br_taken_i | input | 1 | Lane X execute stage reports its branch as taken |
| issue_cnt_o | output | 2 | Number of slots leaving decode this cycle |
| lane_valid_o | output | 3 | Lane carries an issued instruction (bit 0 X, 1 Y, 2 Z) |
| lane_cls_o | output | 6 | Class code per lane |
| lane_dst_o | output | 3×REG_W | Destination tag per lane |
| lane_src1_o | output | 3×REG_W | First source tag per lane |
| lane_src2_o | output | 3×REG_W | Second source tag per lane |
| flush_o | output | 1 | Redirect: squash buffered work and refetch |

## Verification
Some properties are checked on every cycle. Lane capabilities must hold. The issue count must agree with the number of valid lanes. No lane may receive an operand whose scoreboard countdown is still running. A redirect must follow a branch on lane X and must coincide with zero issue. Steering order, the one-cycle load-use bubble and the fact that an ALU result is usable at once can only be shown by the bench's directed groups. The same holds for intra-group cuts, write-after-write stalls, the special handling of register 0, and ignored taken pulses, because each depends on a specific sequence of groups across cycles.

// File: rtl/iss_pkg.sv
package iss_pkg;

   localparam int unsigned SLOTS = 3;
   localparam int unsigned LANES = 3;

   localparam logic [1:0] LN_X = 2'd0;
   localparam logic [1:0] LN_Y = 2'd1;
   localparam logic [1:0] LN_Z = 2'd2;

   typedef enum logic [1:0] {
      CLS_ALU    = 2'd0,
      CLS_LOAD   = 2'd1,
      CLS_STORE  = 2'd2,
      CLS_BRANCH = 2'd3
   } op_cls_e;

   function automatic logic cls_writes(op_cls_e c);
      return (c == CLS_ALU) || (c == CLS_LOAD);
   endfunction

   function automatic logic cls_mem(op_cls_e c);
      return (c == CLS_LOAD) || (c == CLS_STORE);
   endfunction

endpackage

// File: rtl/iss_steer.sv
// Greedy in-order lane allocation, computed as if every older slot issues.
module iss_steer
   import iss_pkg::*;
(
   input  logic [SLOTS-1:0] valid_i,
   input  op_cls_e          cls_i     [SLOTS],
   output logic [SLOTS-1:0] fits_o,
   output logic [1:0]       lane_of_o [SLOTS]
);

   logic [LANES-1:0] free;
   logic             younger_br;
   logic             got;
   logic [1:0]       pick;

   always_comb begin
      free       = '1;
      fits_o     = '0;
      younger_br = 1'b0;
      got        = 1'b0;
      pick       = LN_X;
      for (int k = 0; k < SLOTS; k++) lane_of_o[k] = LN_X;
      for (int k = 0; k < SLOTS; k++) begin
         younger_br = 1'b0;
         for (int j = 0; j < SLOTS; j++)
            if (j > k && valid_i[j] && cls_i[j] == CLS_BRANCH) younger_br = 1'b1;
         got  = 1'b0;
         pick = LN_X;
         case (cls_i[k])
            CLS_BRANCH: begin
               if (free[LN_X]) begin got = 1'b1; pick = LN_X; end
            end
            CLS_LOAD, CLS_STORE: begin
               if (free[LN_Y])      begin got = 1'b1; pick = LN_Y; end
               else if (free[LN_Z]) begin got = 1'b1; pick = LN_Z; end
            end
            default: begin
               if (free[LN_X] && !younger_br) begin got = 1'b1; pick = LN_X; end
               else if (free[LN_Y])           begin got = 1'b1; pick = LN_Y; end
               else if (free[LN_Z])           begin got = 1'b1; pick = LN_Z; end
               else if (free[LN_X])           begin got = 1'b1; pick = LN_X; end
            end
         endcase
         if (got && valid_i[k]) begin
            fits_o[k]    = 1'b1;
            free[pick]   = 1'b0;
            lane_of_o[k] = pick;
         end
      end
   end

endmodule

// File: rtl/iss_group_dep.sv
// Dependencies between slots of the same decode group.
module iss_group_dep
   import iss_pkg::*;
#(
   parameter int unsigned REG_W    = 5,
   parameter bit          ZERO_REG = 1'b1
) (
   input  logic [SLOTS-1:0] valid_i,
   input  op_cls_e          cls_i  [SLOTS],
   input  logic [REG_W-1:0] dst_i  [SLOTS],
   input  logic [REG_W-1:0] src1_i [SLOTS],
   input  logic [REG_W-1:0] src2_i [SLOTS],
   output logic [SLOTS-1:0] blocked_o
);

   function automatic logic live(logic [REG_W-1:0] r);
      return !(ZERO_REG && r == '0);
   endfunction

   always_comb begin
      blocked_o = '0;
      for (int k = 1; k < SLOTS; k++) begin
         for (int j = 0; j < SLOTS; j++) begin
            if (j < k && valid_i[j]) begin
               if (cls_i[j] == CLS_BRANCH) blocked_o[k] = 1'b1;
               if (cls_writes(cls_i[j]) && live(dst_i[j])) begin
                  if (src1_i[k] == dst_i[j] || src2_i[k] == dst_i[j]) blocked_o[k] = 1'b1;
                  if (cls_writes(cls_i[k]) && dst_i[k] == dst_i[j])   blocked_o[k] = 1'b1;
               end
            end
         end
      end
   end

endmodule

// File: rtl/iss_scoreboard.sv
// Per-register countdown of cycles until a result can be bypassed.
module iss_scoreboard
   import iss_pkg::*;
#(
   parameter int unsigned NUM_REGS = 32,
   parameter int unsigned REG_W    = 5,
   parameter int unsigned LOAD_LAT = 2,
   parameter int unsigned ALU_LAT  = 1,
   parameter bit          ZERO_REG = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [LANES-1:0]    wr_en_i,
   input  logic [REG_W-1:0]    wr_reg_i [LANES],
   input  op_cls_e             wr_cls_i [LANES],
   input  op_cls_e             q_cls_i  [SLOTS],
   input  logic [REG_W-1:0]    q_dst_i  [SLOTS],
   input  logic [REG_W-1:0]    q_src1_i [SLOTS],
   input  logic [REG_W-1:0]    q_src2_i [SLOTS],
   output logic [SLOTS-1:0]    hazard_o,
   output logic [NUM_REGS-1:0] busy_o
);

   localparam int unsigned CNT_W = (LOAD_LAT > 1) ? $clog2(LOAD_LAT) : 1;
   localparam logic [CNT_W-1:0] LD_SET  = CNT_W'(LOAD_LAT - 1);
   localparam logic [CNT_W-1:0] ALU_SET = CNT_W'(ALU_LAT - 1);

   logic [CNT_W-1:0] cnt [NUM_REGS];

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      if (ZERO_REG && r == 0) begin : g_tied
         assign cnt[r] = '0;
      end else begin : g_cnt
         logic [CNT_W-1:0] cnt_q;
         logic [CNT_W-1:0] cnt_d;
         always_comb begin
            cnt_d = (cnt_q != '0) ? cnt_q - CNT_W'(1) : '0;
            for (int l = 0; l < LANES; l++)
               if (wr_en_i[l] && cls_writes(wr_cls_i[l]) && wr_reg_i[l] == REG_W'(r))
                  cnt_d = (wr_cls_i[l] == CLS_LOAD) ? LD_SET : ALU_SET;
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt_q <= '0;
            else        cnt_q <= cnt_d;
         end
         assign cnt[r] = cnt_q;
      end
      assign busy_o[r] = (cnt[r] != '0);
   end

   for (genvar k = 0; k < SLOTS; k++) begin : g_query
      logic [CNT_W-1:0] own;
      assign own = (q_cls_i[k] == CLS_LOAD) ? LD_SET : ALU_SET;
      assign hazard_o[k] = busy_o[q_src1_i[k]] || busy_o[q_src2_i[k]] ||
                           (cls_writes(q_cls_i[k]) && cnt[q_dst_i[k]] > own);
   end

   if (LOAD_LAT > 1) begin : g_ld_chk
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         // R5: an issued load leaves its register pending in the next cycle
         p_load_marks_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en_i[l] && wr_cls_i[l] == CLS_LOAD && !(ZERO_REG && wr_reg_i[l] == '0))
            |=> busy_o[$past(wr_reg_i[l])]);
      end
   end

endmodule

// File: rtl/issue_unit.sv
module issue_unit
   import iss_pkg::*;
#(
   parameter int unsigned NUM_REGS = 32,
   parameter int unsigned LOAD_LAT = 2,
   parameter int unsigned ALU_LAT  = 1,
   parameter bit          ZERO_REG = 1'b1,
   localparam int unsigned REG_W   = $clog2(NUM_REGS)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [SLOTS-1:0]         slot_valid_i,
   input  logic [2*SLOTS-1:0]       slot_cls_i,
   input  logic [SLOTS*REG_W-1:0]   slot_dst_i,
   input  logic [SLOTS*REG_W-1:0]   slot_src1_i,
   input  logic [SLOTS*REG_W-1:0]   slot_src2_i,
   input  logic                     br_taken_i,
   output logic [1:0]               issue_cnt_o,
   output logic [LANES-1:0]         lane_valid_o,
   output logic [2*LANES-1:0]       lane_cls_o,
   output logic [LANES*REG_W-1:0]   lane_dst_o,
   output logic [LANES*REG_W-1:0]   lane_src1_o,
   output logic [LANES*REG_W-1:0]   lane_src2_o,
   output logic                     flush_o
);

   initial begin
      p_lat_order_r5: assert (ALU_LAT >= 1 && LOAD_LAT >= ALU_LAT)
         else $fatal(1, "latencies must satisfy 1 <= ALU_LAT <= LOAD_LAT");
      p_regs_pow2_r8: assert (NUM_REGS >= 2 && NUM_REGS == (1 << REG_W))
         else $fatal(1, "NUM_REGS must be a power of two");
   end

   op_cls_e          s_cls  [SLOTS];
   logic [REG_W-1:0] s_dst  [SLOTS];
   logic [REG_W-1:0] s_src1 [SLOTS];
   logic [REG_W-1:0] s_src2 [SLOTS];

   for (genvar k = 0; k < SLOTS; k++) begin : g_unpack
      assign s_cls[k]  = op_cls_e'(slot_cls_i[2*k +: 2]);
      assign s_dst[k]  = slot_dst_i[REG_W*k +: REG_W];
      assign s_src1[k] = slot_src1_i[REG_W*k +: REG_W];
      assign s_src2[k] = slot_src2_i[REG_W*k +: REG_W];
   end

   logic [SLOTS-1:0]  fits, blocked, hazard, go;
   logic [1:0]        lane_of [SLOTS];
   logic [NUM_REGS-1:0] sb_busy;
   logic              br_in_x0_q;

   logic             l_v    [LANES];
   op_cls_e          l_cls  [LANES];
   logic [REG_W-1:0] l_dst  [LANES];
   logic [REG_W-1:0] l_src1 [LANES];
   logic [REG_W-1:0] l_src2 [LANES];
   logic [LANES-1:0] l_v_vec;

   iss_steer u_steer (
      .valid_i   (slot_valid_i),
      .cls_i     (s_cls),
      .fits_o    (fits),
      .lane_of_o (lane_of)
   );

   iss_group_dep #(.REG_W(REG_W), .ZERO_REG(ZERO_REG)) u_dep (
      .valid_i   (slot_valid_i),
      .cls_i     (s_cls),
      .dst_i     (s_dst),
      .src1_i    (s_src1),
      .src2_i    (s_src2),
      .blocked_o (blocked)
   );

   iss_scoreboard #(
      .NUM_REGS (NUM_REGS),
      .REG_W    (REG_W),
      .LOAD_LAT (LOAD_LAT),
      .ALU_LAT  (ALU_LAT),
      .ZERO_REG (ZERO_REG)
   ) u_sb (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en_i  (l_v_vec),
      .wr_reg_i (l_dst),
      .wr_cls_i (l_cls),
      .q_cls_i  (s_cls),
      .q_dst_i  (s_dst),
      .q_src1_i (s_src1),
      .q_src2_i (s_src2),
      .hazard_o (hazard),
      .busy_o   (sb_busy)
   );

   assign flush_o = br_taken_i && br_in_x0_q;

   // Leading run of slots that are present, placeable and hazard free.
   always_comb begin
      go = '0;
      for (int k = 0; k < SLOTS; k++) begin
         go[k] = slot_valid_i[k] && fits[k] && !blocked[k] && !hazard[k] && !flush_o;
         if (k > 0) go[k] = go[k] && go[k-1];
      end
      issue_cnt_o = '0;
      for (int k = 0; k < SLOTS; k++) issue_cnt_o = issue_cnt_o + 2'(go[k]);
   end

   always_comb begin
      for (int l = 0; l < LANES; l++) begin
         l_v[l]    = 1'b0;
         l_cls[l]  = CLS_ALU;
         l_dst[l]  = '0;
         l_src1[l] = '0;
         l_src2[l] = '0;
         for (int k = 0; k < SLOTS; k++) begin
            if (go[k] && lane_of[k] == 2'(l)) begin
               l_v[l]    = 1'b1;
               l_cls[l]  = s_cls[k];
               l_dst[l]  = s_dst[k];
               l_src1[l] = s_src1[k];
               l_src2[l] = s_src2[k];
            end
         end
      end
   end

   for (genvar l = 0; l < LANES; l++) begin : g_pack
      assign l_v_vec[l]                      = l_v[l];
      assign lane_valid_o[l]                 = l_v[l];
      assign lane_cls_o[2*l +: 2]            = l_cls[l];
      assign lane_dst_o[REG_W*l +: REG_W]    = l_dst[l];
      assign lane_src1_o[REG_W*l +: REG_W]   = l_src1[l];
      assign lane_src2_o[REG_W*l +: REG_W]   = l_src2[l];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) br_in_x0_q <= 1'b0;
      else        br_in_x0_q <= l_v[LN_X] && l_cls[LN_X] == CLS_BRANCH;
   end

   // R1: lanes in use match the count handed back to decode
   p_count_matches_lanes_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(lane_valid_o) == int'(issue_cnt_o));

   // R2: lane capability limits
   p_x_no_mem_r2: assert property (@(posedge clk) disable iff (!rst_n)
      l_v[LN_X] |-> !cls_mem(l_cls[LN_X]));
   p_y_no_branch_r2: assert property (@(posedge clk) disable iff (!rst_n)
      l_v[LN_Y] |-> l_cls[LN_Y] != CLS_BRANCH);
   p_z_no_branch_r2: assert property (@(posedge clk) disable iff (!rst_n)
      l_v[LN_Z] |-> l_cls[LN_Z] != CLS_BRANCH);

   // R5: no lane receives an operand that is still counting down
   for (genvar l = 0; l < LANES; l++) begin : g_src_chk
      p_no_busy_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
         l_v[l] |-> !sb_busy[l_src1[l]] && !sb_busy[l_src2[l]]);
   end

   // R10: a redirect silences issue and follows a branch on lane X
   p_flush_silences_r10: assert property (@(posedge clk) disable iff (!rst_n)
      flush_o |-> lane_valid_o == '0);
   p_flush_needs_branch_r10: assert property (@(posedge clk) disable iff (!rst_n)
      flush_o |-> $past(l_v[LN_X] && l_cls[LN_X] == CLS_BRANCH));

endmodule

// File: tb/tb_issue_unit.sv
module tb_issue_unit;
   import iss_pkg::*;

   localparam int RW = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic [2:0]      in_v = '0;
   logic [5:0]      in_c = '0;
   logic [3*RW-1:0] in_d = '0, in_a = '0, in_b = '0;
   logic            in_br = 1'b0;

   logic [2:0]      st_v = '0;
   logic [5:0]      st_c = '0;
   logic [3*RW-1:0] st_d = '0, st_a = '0, st_b = '0;

   logic [1:0]      issue_cnt;
   logic [2:0]      lane_valid;
   logic [5:0]      lane_cls;
   logic [3*RW-1:0] lane_dst, lane_src1, lane_src2;
   logic            flush;

   issue_unit dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .slot_valid_i (in_v),
      .slot_cls_i   (in_c),
      .slot_dst_i   (in_d),
      .slot_src1_i  (in_a),
      .slot_src2_i  (in_b),
      .br_taken_i   (in_br),
      .issue_cnt_o  (issue_cnt),
      .lane_valid_o (lane_valid),
      .lane_cls_o   (lane_cls),
      .lane_dst_o   (lane_dst),
      .lane_src1_o  (lane_src1),
      .lane_src2_o  (lane_src2),
      .flush_o      (flush)
   );

   int    n_cmp = 0;
   int    n_bad = 0;
   bit    done  = 1'b0;

   int              q_cnt [$];
   logic [2:0]      q_lv  [$];
   logic [3*RW-1:0] q_ld  [$];
   logic            q_fl  [$];
   string           q_req [$];

   task automatic put(input int k, input op_cls_e cl, input int dd, input int s1, input int s2);
      st_v[k]          = 1'b1;
      st_c[2*k +: 2]   = cl;
      st_d[RW*k +: RW] = RW'(dd);
      st_a[RW*k +: RW] = RW'(s1);
      st_b[RW*k +: RW] = RW'(s2);
   endtask

   // Apply the staged group for one cycle and queue what the lanes must show.
   task automatic step(input int ecnt, input logic [2:0] elv, input int x, input int y,
                       input int z, input logic efl, input logic br, input string req);
      @(negedge clk);
      in_v = st_v; in_c = st_c; in_d = st_d; in_a = st_a; in_b = st_b; in_br = br;
      q_cnt.push_back(ecnt);
      q_lv.push_back(elv);
      q_ld.push_back({RW'(z), RW'(y), RW'(x)});
      q_fl.push_back(efl);
      q_req.push_back(req);
      st_v = '0; st_c = '0; st_d = '0; st_a = '0; st_b = '0;
   endtask

   task automatic idle(input string req);
      step(0, 3'b000, 0, 0, 0, 1'b0, 1'b0, req);
   endtask

   // Monitor: compare just before the next rising edge.
   initial begin
      forever begin
         @(negedge clk);
         #4;
         if (q_cnt.size() > 0) begin
            int              ec;
            logic [2:0]      elv;
            logic [3*RW-1:0] eld;
            logic            efl;
            string           rq;
            ec  = q_cnt.pop_front();
            elv = q_lv.pop_front();
            eld = q_ld.pop_front();
            efl = q_fl.pop_front();
            rq  = q_req.pop_front();
            n_cmp++;
            if (int'(issue_cnt) != ec || lane_valid !== elv || lane_dst !== eld || flush !== efl) begin
               n_bad++;
               $display("FAIL %s: got cnt=%0d lanes=%b dst(zyx)=%h flush=%b, expected cnt=%0d lanes=%b dst(zyx)=%h flush=%b",
                        rq, issue_cnt, lane_valid, lane_dst, flush, ec, elv, eld, efl);
            end
         end
      end
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R12: quiet after reset
      idle("R12");

      // R1 R3: three ALU ops fill X, Y, Z in order
      put(0, CLS_ALU, 1, 2, 3); put(1, CLS_ALU, 4, 2, 3); put(2, CLS_ALU, 5, 6, 7);
      step(3, 3'b111, 1, 4, 5, 1'b0, 1'b0, "R1 R3 alu triple");

      // R2 R3: load to Y, store to Z, ALU to X
      put(0, CLS_LOAD, 6, 10, 0); put(1, CLS_STORE, 7, 11, 12); put(2, CLS_ALU, 8, 13, 14);
      step(3, 3'b111, 8, 6, 7, 1'b0, 1'b0, "R2 R3 mixed memory");
      idle("R12 drain"); idle("R12 drain");

      // R4: third load finds no memory lane
      put(0, CLS_LOAD, 9, 1, 0); put(1, CLS_LOAD, 12, 2, 0); put(2, CLS_LOAD, 13, 3, 0);
      step(2, 3'b110, 0, 9, 12, 1'b0, 1'b0, "R4 three loads");
      put(0, CLS_LOAD, 13, 3, 0);
      step(1, 3'b010, 0, 13, 0, 1'b0, 1'b0, "R4 leftover load");
      idle("R4 drain"); idle("R4 drain");

      // R5: load-use bubble, younger independent slot waits too
      put(0, CLS_LOAD, 14, 20, 0);
      step(1, 3'b010, 0, 14, 0, 1'b0, 1'b0, "R5 load issues");
      put(0, CLS_ALU, 15, 14, 0); put(1, CLS_ALU, 3, 1, 2);
      step(0, 3'b000, 0, 0, 0, 1'b0, 1'b0, "R5 load-use stall");
      put(0, CLS_ALU, 15, 14, 0); put(1, CLS_ALU, 3, 1, 2);
      step(2, 3'b011, 15, 3, 0, 1'b0, 1'b0, "R5 after bubble");
      put(0, CLS_ALU, 16, 0, 0);
      step(1, 3'b001, 16, 0, 0, 1'b0, 1'b0, "R5 alu producer");
      put(0, CLS_ALU, 17, 16, 0);
      step(1, 3'b001, 17, 0, 0, 1'b0, 1'b0, "R5 alu consumer next cycle");

      // R6: intra-group RAW and WAW cuts
      put(0, CLS_ALU, 18, 1, 0); put(1, CLS_ALU, 19, 18, 0); put(2, CLS_ALU, 20, 0, 0);
      step(1, 3'b001, 18, 0, 0, 1'b0, 1'b0, "R6 raw cut");
      put(0, CLS_ALU, 19, 18, 0); put(1, CLS_ALU, 20, 0, 0);
      step(2, 3'b011, 19, 20, 0, 1'b0, 1'b0, "R6 remainder");
      put(0, CLS_ALU, 24, 1, 0); put(1, CLS_ALU, 24, 2, 0);
      step(1, 3'b001, 24, 0, 0, 1'b0, 1'b0, "R6 waw cut");
      put(0, CLS_ALU, 24, 2, 0);
      step(1, 3'b001, 24, 0, 0, 1'b0, 1'b0, "R6 waw remainder");

      // R8: register 0 is never a dependency
      put(0, CLS_ALU, 0, 1, 0); put(1, CLS_ALU, 21, 0, 0);
      step(2, 3'b011, 0, 21, 0, 1'b0, 1'b0, "R8 r0 in group");
      put(0, CLS_LOAD, 0, 1, 0);
      step(1, 3'b010, 0, 0, 0, 1'b0, 1'b0, "R8 load to r0");
      put(0, CLS_ALU, 22, 0, 0);
      step(1, 3'b001, 22, 0, 0, 1'b0, 1'b0, "R8 reader of r0 no bubble");

      // R7: ALU write behind a pending load
      put(0, CLS_LOAD, 23, 1, 0);
      step(1, 3'b010, 0, 23, 0, 1'b0, 1'b0, "R7 load");
      put(0, CLS_ALU, 23, 2, 0);
      step(0, 3'b000, 0, 0, 0, 1'b0, 1'b0, "R7 waw stall");
      put(0, CLS_ALU, 23, 2, 0);
      step(1, 3'b001, 23, 0, 0, 1'b0, 1'b0, "R7 waw release");

      // R11: a store destination field never delays a reader
      put(0, CLS_STORE, 25, 1, 2);
      step(1, 3'b010, 0, 25, 0, 1'b0, 1'b0, "R11 store");
      put(0, CLS_ALU, 26, 25, 0);
      step(1, 3'b001, 26, 0, 0, 1'b0, 1'b0, "R11 reader of store tag");

      // R3 R9: ALU skips X for a younger branch; branch closes the group
      put(0, CLS_ALU, 27, 1, 0); put(1, CLS_BRANCH, 28, 2, 0); put(2, CLS_ALU, 29, 0, 0);
      step(2, 3'b011, 28, 27, 0, 1'b0, 1'b0, "R3 R9 alu before branch");
      // R10: taken resolution flushes and blocks issue
      put(0, CLS_ALU, 29, 0, 0);
      step(0, 3'b000, 0, 0, 0, 1'b1, 1'b1, "R10 taken flush");
      put(0, CLS_ALU, 30, 0, 0);
      step(1, 3'b001, 30, 0, 0, 1'b0, 1'b0, "R10 refetched group");
      // R10: taken pulse with no branch in X is ignored
      put(0, CLS_ALU, 31, 0, 0);
      step(1, 3'b001, 31, 0, 0, 1'b0, 1'b1, "R10 stray taken ignored");

      // R3 R4: two loads and a branch fill all lanes
      put(0, CLS_LOAD, 2, 1, 0); put(1, CLS_LOAD, 3, 1, 0); put(2, CLS_BRANCH, 4, 5, 0);
      step(3, 3'b111, 4, 2, 3, 1'b0, 1'b0, "R3 R4 load load branch");
      step(0, 3'b000, 0, 0, 0, 1'b0, 1'b0, "R10 not taken");

      // R9: second branch waits for the next cycle
      put(0, CLS_BRANCH, 5, 1, 0); put(1, CLS_BRANCH, 6, 1, 0);
      step(1, 3'b001, 5, 0, 0, 1'b0, 1'b0, "R9 branch pair");
      put(0, CLS_BRANCH, 6, 1, 0);
      step(1, 3'b001, 6, 0, 0, 1'b0, 1'b0, "R9 second branch");
      idle("R10 not taken end");
      idle("R12 final");

      repeat (2) @(negedge clk);
      #6;
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule